// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Bus Sequencer

This block is the digital control side of a sampling converter that has four track/hold channels and two input banks. A host talks to it over one shared 12-bit parallel bus. It uses an active-low chip select, an active-low write strobe and an active-low read strobe. The host writes a 4-bit mode word on the low bus bits. That word selects bank A or bank B, the number of channels to digitize per sample (one to four), or power-down.

An active-low convert strobe freezes all four channels of the selected bank in the same clock edge. The sequencer then converts channel 1 through channel N. Each channel takes a fixed number of clock cycles. After the last channel, an active-low completion flag goes low. The host then reads the N results one per read strobe over the same bus. The analog part is modelled by two flat sample-value input buses, one per bank. Bus three-state control is exposed as a data output plus an output enable.

The sequencer has three states:

- `ST_IDLE`: waiting for a convert strobe.
- `ST_CONV`: stepping through the requested channels.
- `ST_DOWN`: powered down.

It has five transitions:

- `ST_IDLE -> ST_CONV` on an accepted convert strobe.
- `ST_CONV -> ST_IDLE` when the last requested channel finishes.
- `ST_IDLE -> ST_DOWN` when the active mode word has its power-down bit set.
- `ST_DOWN -> ST_IDLE` when a mode word without the power-down bit becomes active.
- `ST_IDLE -> ST_IDLE` when a convert strobe is refused.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the active mode is bank A with one channel per sample, `done_n` is high and `bus_oe` is low.
- R2: A write happens at the first clock edge at which `cs_n` and `wr_n` are both low after either was high. It loads `bus_in[3:0]` as the mode word: bit 3 selects power-down, bit 2 selects bank B (0 = bank A), and bits 1:0 plus one give the channel count N.
- R3: While `cs_n` is high, write and read strobes have no effect: the mode and the read position are unchanged, and `bus_oe` stays low.
- R4: `bus_oe` is high exactly while `cs_n` and `rd_n` are both low. `bus_out` then carries the result at the current read position.
- R5: A convert strobe is accepted at the first clock edge where `cnv_n` is low after being high. All four sample values of the selected bank are captured at that edge. Later changes on the sample inputs do not alter the results of that sequence.
- R6: `done_n` goes low exactly N*CONV_CYC clock edges after the edge that accepted the convert strobe, and not before.
- R7: Reads return channel 1 to channel N in order, then wrap to channel 1. The read position advances when a read ends (`cs_n` or `rd_n` rises). The start of a read returns `done_n` high.
- R8: A convert strobe is ignored unless at least ACQ_CYC idle cycles have passed since the last sequence completed (or since reset). An ignored strobe leaves earlier results and `done_n` unchanged.
- R9: While the active mode has the power-down bit set, convert strobes are ignored. Conversions resume after a mode word without that bit is written.
- R10: A mode write made during a conversion sequence is held. It does not affect the running sequence and becomes active once the sequence has completed.
- R11: A convert strobe arriving during a conversion sequence is ignored and does not change its completion time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| cnv_n | input | 1 | Active-low convert strobe |
| bus_in | input | W | Bus value as seen at the pads (mode word on bits 3:0) |
| bus_out | output | W | Result driven toward the pads |
| bus_oe | output | 1 | Pad output enable |
| done_n | output | 1 | Active-low completion flag |
| samp_a | input | NCH*W | Bank A sample values, channel 1 in the low W bits |
| samp_b | input | NCH*W | Bank B sample values, channel 1 in the low W bits |

## Verification
A mode write takes effect at the first rising edge after the strobes fall. A read position advances at the first edge after a read ends. The completion flag falls on the N*CONV_CYC-th edge after the accepting edge.

The bench drives all inputs just after falling clock edges and samples one time unit after rising edges. It counts rising edges from the accepting edge. It checks `done_n` high on edge N*CONV_CYC-1 and low on edge N*CONV_CYC. Read data and `bus_oe` are checked on the edge after both strobes are low. Ignored strobes are checked after the refusal window has passed, through `done_n` and the data read back.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CNT_W = 2;

    typedef struct packed {
        logic             pd;
        logic             bank;
        logic [CNT_W-1:0] cnt_m1;
    } seq_mode_t;

    localparam seq_mode_t MODE_RESET = '{pd: 1'b0, bank: 1'b0, cnt_m1: '0};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_DOWN
    } seq_state_t;

endpackage

// File: rtl/adc_seq_strobe.sv
module adc_seq_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic cnv_n,
    output logic wr_evt,
    output logic rd_start,
    output logic rd_end,
    output logic cnv_evt,
    output logic bus_oe
);
    logic wr_act, rd_act;
    logic wr_act_q, rd_act_q, cnv_hi_q;

    assign wr_act = ~cs_n & ~wr_n;
    assign rd_act = ~cs_n & ~rd_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
            cnv_hi_q <= 1'b1;
        end else begin
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
            cnv_hi_q <= cnv_n;
        end
    end

    always_comb begin
        wr_evt   = wr_act & ~wr_act_q;
        rd_start = rd_act & ~rd_act_q;
        rd_end   = ~rd_act & rd_act_q;
        cnv_evt  = ~cnv_n & cnv_hi_q;
        bus_oe   = rd_act;
    end

    // R3
    cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !wr_evt && !rd_start);

endmodule

// File: rtl/adc_seq_mode.sv
module adc_seq_mode
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_evt,
    input  logic [3:0] wdata,
    input  logic       busy,
    output seq_mode_t  mode
);
    seq_mode_t held;
    logic      held_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= MODE_RESET;
            held     <= MODE_RESET;
            held_vld <= 1'b0;
        end else if (wr_evt) begin
            if (busy) begin
                held     <= seq_mode_t'(wdata);
                held_vld <= 1'b1;
            end else begin
                mode     <= seq_mode_t'(wdata);
                held_vld <= 1'b0;
            end
        end else if (held_vld && !busy) begin
            mode     <= held;
            held_vld <= 1'b0;
        end
    end

    // R10
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode));

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int W        = 12,
    parameter int NCH      = 4,
    parameter int CONV_CYC = 4,
    parameter int ACQ_CYC  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_mode_t        mode,
    input  logic             cnv_evt,
    input  logic             rd_start,
    input  logic             rd_end,
    input  logic [NCH*W-1:0] samp_a,
    input  logic [NCH*W-1:0] samp_b,
    output logic             busy,
    output logic             done_n,
    output logic [W-1:0]     rd_data
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int TW  = $clog2(CONV_CYC + 1);
    localparam int AW  = $clog2(ACQ_CYC + 1);
    localparam logic [TW-1:0]  T_LAST  = TW'(CONV_CYC - 1);
    localparam logic [AW-1:0]  ACQ_MIN = AW'(ACQ_CYC);
    localparam logic [CHW-1:0] CH_MAX  = CHW'(NCH - 1);

    seq_state_t     state, state_nx;
    logic [W-1:0]   in_a [NCH];
    logic [W-1:0]   in_b [NCH];
    logic [W-1:0]   held [NCH];
    logic [W-1:0]   res  [NCH];
    logic [TW-1:0]  tmr;
    logic [CHW-1:0] ch, ch_last, rd_ptr, req_last;
    logic [AW-1:0]  acq_cnt;
    logic           accept, seq_end;

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign in_a[g] = samp_a[g*W +: W];
        assign in_b[g] = samp_b[g*W +: W];
    end

    assign req_last = (int'(mode.cnt_m1) > NCH - 1) ? CH_MAX : CHW'(mode.cnt_m1);
    assign accept   = (state == ST_IDLE) && cnv_evt && !mode.pd && (acq_cnt >= ACQ_MIN);
    assign seq_end  = (state == ST_CONV) && (tmr == T_LAST) && (ch == ch_last);
    assign busy     = (state == ST_CONV);
    assign rd_data  = res[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (mode.pd)     state_nx = ST_DOWN;
                else if (accept) state_nx = ST_CONV;
            end
            ST_CONV: if (seq_end)  state_nx = ST_IDLE;
            ST_DOWN: if (!mode.pd) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr     <= '0;
            ch      <= '0;
            ch_last <= '0;
            rd_ptr  <= '0;
            acq_cnt <= '0;
            done_n  <= 1'b1;
            for (int i = 0; i < NCH; i++) begin
                held[i] <= '0;
                res[i]  <= '0;
            end
        end else begin
            if (state != ST_CONV && acq_cnt < ACQ_MIN) acq_cnt <= acq_cnt + 1'b1;
            if (rd_start) done_n <= 1'b1;
            if (rd_end)   rd_ptr <= (rd_ptr == ch_last) ? '0 : rd_ptr + 1'b1;
            if (accept) begin
                for (int i = 0; i < NCH; i++) held[i] <= mode.bank ? in_b[i] : in_a[i];
                tmr     <= '0;
                ch      <= '0;
                ch_last <= req_last;
                rd_ptr  <= '0;
                done_n  <= 1'b1;
            end else if (state == ST_CONV) begin
                if (tmr == T_LAST) begin
                    res[ch] <= held[ch];
                    tmr     <= '0;
                    if (ch == ch_last) begin
                        done_n  <= 1'b0;
                        acq_cnt <= '0;
                    end else begin
                        ch <= ch + 1'b1;
                    end
                end else begin
                    tmr <= tmr + 1'b1;
                end
            end
        end
    end

    // R6
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_n) |-> $past(state == ST_CONV) && (state == ST_IDLE));

    // R7
    rd_ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= ch_last);

    // R9
    down_no_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOWN) |=> (state != ST_CONV));

    // R11
    conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV) && !seq_end |=> (state == ST_CONV) && $stable(ch_last));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int W        = 12,
    parameter int NCH      = 4,
    parameter int CONV_CYC = 4,
    parameter int ACQ_CYC  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             cnv_n,
    input  logic [W-1:0]     bus_in,
    output logic [W-1:0]     bus_out,
    output logic             bus_oe,
    output logic             done_n,
    input  logic [NCH*W-1:0] samp_a,
    input  logic [NCH*W-1:0] samp_b
);
    logic      wr_evt, rd_start, rd_end, cnv_evt, busy;
    seq_mode_t mode;
    logic      unused_hi;

    assign unused_hi = ^bus_in[W-1:4];

    adc_seq_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .rd_n     (rd_n),
        .cnv_n    (cnv_n),
        .wr_evt   (wr_evt),
        .rd_start (rd_start),
        .rd_end   (rd_end),
        .cnv_evt  (cnv_evt),
        .bus_oe   (bus_oe)
    );

    adc_seq_mode u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_evt (wr_evt),
        .wdata  (bus_in[3:0]),
        .busy   (busy),
        .mode   (mode)
    );

    adc_seq_core #(
        .W        (W),
        .NCH      (NCH),
        .CONV_CYC (CONV_CYC),
        .ACQ_CYC  (ACQ_CYC)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .cnv_evt  (cnv_evt),
        .rd_start (rd_start),
        .rd_end   (rd_end),
        .samp_a   (samp_a),
        .samp_b   (samp_b),
        .busy     (busy),
        .done_n   (done_n),
        .rd_data  (bus_out)
    );

    // R4
    oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !cs_n && !rd_n);

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 12;
    localparam int NCH = 4;
    localparam int CC  = 4;
    localparam int ACQ = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, cnv_n = 1'b1;
    logic host_drv = 1'b0;
    logic [W-1:0] host_val = '0;
    logic [W-1:0] bus_out;
    logic bus_oe, done_n;
    logic [W-1:0] sa [NCH];
    logic [W-1:0] sb [NCH];
    logic [W-1:0] exp_w [NCH];
    logic [NCH*W-1:0] samp_a, samp_b;
    wire  [W-1:0] bus_pad;
    int checks = 0, fails = 0;
    bit finished = 0;

    assign bus_pad = bus_oe ? bus_out : (host_drv ? host_val : {W{1'bz}});
    assign samp_a = {sa[3], sa[2], sa[1], sa[0]};
    assign samp_b = {sb[3], sb[2], sb[1], sb[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(.W(W), .NCH(NCH), .CONV_CYC(CC), .ACQ_CYC(ACQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cnv_n(cnv_n), .bus_in(bus_pad), .bus_out(bus_out), .bus_oe(bus_oe),
        .done_n(done_n), .samp_a(samp_a), .samp_b(samp_b)
    );

    function automatic logic [W-1:0] pick(input bit bank, input int c);
        return bank ? sb[c] : sa[c];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic shuffle();
        for (int i = 0; i < NCH; i++) begin
            sa[i] = W'($urandom);
            sb[i] = W'($urandom);
        end
    endtask

    task automatic wr_mode(input logic [3:0] val, input bit sel);
        @(negedge clk);
        cs_n = ~sel; wr_n = 1'b0; host_drv = 1'b1; host_val = {8'h00, val};
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1; host_drv = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Accepted conversion; optional mid-sequence strobe and mode write.
    task automatic conv(input int n, input bit bank, input bit mid_cnv,
                        input bit mid_wr, input logic [3:0] mid_val, input string req);
        for (int i = 0; i < NCH; i++) exp_w[i] = pick(bank, i);
        @(negedge clk); cnv_n = 1'b0;
        @(posedge clk);
        for (int k = 1; k <= n*CC; k++) begin
            @(negedge clk);
            if (k == 1) begin cnv_n = 1'b1; shuffle(); end
            if (mid_cnv && k == 2) cnv_n = 1'b0;
            if (mid_cnv && k == 3) cnv_n = 1'b1;
            if (mid_wr && k == 2) begin
                cs_n = 1'b0; wr_n = 1'b0; host_drv = 1'b1; host_val = {8'h00, mid_val};
            end
            if (mid_wr && k == 3) begin cs_n = 1'b1; wr_n = 1'b1; host_drv = 1'b0; end
            @(posedge clk); #1;
            if (k == n*CC - 1) chk(done_n === 1'b1, {req, " done early"}, int'(done_n), 1);
            if (k == n*CC)     chk(done_n === 1'b0, {req, " done due"}, int'(done_n), 0);
        end
    endtask

    task automatic rd_chk(input logic [W-1:0] e, input string req);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        @(posedge clk); #1;
        chk(bus_oe === 1'b1, {req, " oe"}, int'(bus_oe), 1);
        chk(bus_out === e && bus_pad === e, {req, " data"}, int'(bus_out), int'(e));
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic try_conv();
        @(negedge clk); cnv_n = 1'b0;
        @(negedge clk); cnv_n = 1'b1; shuffle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        shuffle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset outputs
        chk(done_n === 1'b1, "R1 done_n", int'(done_n), 1);
        chk(bus_oe === 1'b0, "R1 bus_oe", int'(bus_oe), 0);
        idle(ACQ + 2);
        // R1 default mode: bank A, one channel
        conv(1, 1'b0, 1'b0, 1'b0, 4'h0, "R1 R6");
        rd_chk(exp_w[0], "R7 R1 first read");
        @(posedge clk); #1;
        chk(done_n === 1'b1, "R7 done cleared by read", int'(done_n), 1);

        // R3 strobes with chip select high
        idle(ACQ + 2);
        wr_mode(4'b0011, 1'b0);
        conv(1, 1'b0, 1'b0, 1'b0, 4'h0, "R3 mode unchanged");
        @(negedge clk); rd_n = 1'b0;
        @(posedge clk); #1;
        chk(bus_oe === 1'b0, "R3 oe off with cs high", int'(bus_oe), 0);
        chk(done_n === 1'b0, "R3 read ignored", int'(done_n), 0);
        @(negedge clk); rd_n = 1'b1;
        rd_chk(exp_w[0], "R3 R4 ptr unchanged");
        rd_chk(exp_w[0], "R7 wrap n=1");

        // R2 bank B four channels; R11 mid strobe; R10 deferred write
        wr_mode(4'b0111, 1'b1);
        idle(ACQ + 2);
        conv(4, 1'b1, 1'b1, 1'b1, 4'b0001, "R2 R5 R10 R11");
        // R8 immediate retry is refused
        try_conv();
        @(posedge clk); #1;
        chk(done_n === 1'b0, "R8 early strobe ignored", int'(done_n), 0);
        for (int i = 0; i < 4; i++) rd_chk(exp_w[i], "R5 R7 order");
        rd_chk(exp_w[0], "R7 wrap n=4");
        idle(ACQ + 2);
        conv(2, 1'b0, 1'b0, 1'b0, 4'h0, "R10 new mode");
        rd_chk(exp_w[0], "R10 ch1");
        rd_chk(exp_w[1], "R10 ch2");

        // R9 power-down
        wr_mode(4'b1000, 1'b1);
        idle(ACQ + 2);
        try_conv();
        idle(4*CC + 4);
        chk(done_n === 1'b1, "R9 no conversion", int'(done_n), 1);
        rd_chk(exp_w[0], "R9 results kept");
        wr_mode(4'b0010, 1'b1);
        idle(ACQ + 2);
        conv(3, 1'b0, 1'b0, 1'b0, 4'h0, "R9 resumed");
        for (int i = 0; i < 3; i++) rd_chk(exp_w[i], "R9 R7 data");

        // R2 R5 R6 R7 random modes
        for (int it = 0; it < 24; it++) begin
            automatic logic [1:0] c = 2'($urandom);
            automatic bit b = 1'($urandom);
            wr_mode({1'b0, b, c}, 1'b1);
            shuffle();
            idle(ACQ + 2);
            conv(int'(c) + 1, b, 1'($urandom), 1'b0, 4'h0, "R2 R6 random");
            for (int i = 0; i <= int'(c); i++) rd_chk(exp_w[i], "R5 R7 random");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule